// File: doc/BRIEF.md
# Fractional feedback divider splitter

This block converts a requested effective feedback-divider value for a fractional PLL into the two words the PLL consumes: an integer divider and an 8-bit sigma-delta fraction word. Before the split, the request is corrected for a voltage-detection offset. The offset is the difference between a live detection code and a stored calibration code. It is capped from above by a programmable limit and scaled by a 7-bit coefficient.

The arithmetic runs in signed fixed point with 6 fractional bits. A scaled divider that is zero or negative, or one whose integer part exceeds the allowed maximum, is forced to a safe value, and a flag reports the event. The fraction folds in the half-step the sigma-delta modulator adds on its own, and only the top byte of the resulting word is kept.

A caller presents all operands with a one-cycle `in_valid` strobe. The results appear, registered, on the following cycle and stay unchanged until the next strobe.

Top module: `ndiv_frac_split`

## Requirements
- R1: One clock edge after an edge that samples `in_valid` high, `out_valid` is high and the result outputs carry that operand set. After an edge that samples `in_valid` low, `out_valid` is low.
- R2: Reset clears `out_valid`, `n_int`, `sdm_din`, `sat_lo` and `sat_hi` to zero. With no strobe, `n_int`, `sdm_din`, `sat_lo` and `sat_hi` keep their last values.
- R3: The detection delta is `det_cur - det_cal`, with both operands taken as 7-bit two's complement codes. If the delta is larger than the signed 7-bit `det_lim`, it is replaced by `det_lim`. The delta is then multiplied by the unsigned 7-bit `coeff`.
- R4: The scaled divider is `n_eff*64` minus that product. When no clamp applies, `n_int` is the scaled divider divided by 64 (its integer part).
- R5: A scaled divider that is zero or negative is replaced by 64 (integer 1, fraction 0), and `sat_lo` is set for that result.
- R6: After the R5 step, a scaled divider whose integer part exceeds `max_n` is replaced by `max_n*64`, and `sat_hi` is set for that result. When `max_n` is 0, a result can therefore carry both flags, with `n_int` equal to 0.
- R7: Let f be the low 6 bits of the final scaled divider. The word f*128 - 4096 is taken as a 16-bit two's complement value, and `sdm_din` is its bits 15:8. So f=0 gives 0xF0, f=32 gives 0x00 and f=63 gives 0x0F.
- R8: Every result has `n_int` no greater than the `max_n` presented with its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| n_eff | input | 8 | Requested effective divider, integer |
| det_cur | input | 7 | Live detection code, signed |
| det_cal | input | 7 | Stored calibration code, signed |
| det_lim | input | 7 | Upper limit on the detection delta, signed |
| coeff | input | 7 | Detection scaling coefficient, unsigned |
| max_n | input | 8 | Largest allowed integer divider |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| n_int | output | 8 | Integer divider |
| sdm_din | output | 8 | Sigma-delta fraction byte |
| sat_lo | output | 1 | Scaled divider was zero or negative and was forced up |
| sat_hi | output | 1 | Integer part exceeded `max_n` and was forced down |

## Verification
The properties assume that the accumulator parameter is wide enough for the largest product and the largest shifted request. They also assume that operands change only while `in_valid` is sampled, so `$past(max_n)` is the limit that belongs to the result being checked. The stimulus changes inputs only on the falling edge and keeps every field inside its declared width. Its directed cases reach the exact zero, the negative, the equal-to-limit and the above-limit scaled values, as well as the zero-limit corner where both flags are set.

// File: rtl/ndiv_frac_split_pkg.sv
package ndiv_frac_split_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
  } sat_t;
endpackage

// File: rtl/nfs_det_scale.sv
module nfs_det_scale #(
  parameter int DET_W   = 7,
  parameter int COEFF_W = 7,
  parameter int ACC_W   = 24
) (
  input  logic signed [DET_W-1:0]   det_cur,
  input  logic signed [DET_W-1:0]   det_cal,
  input  logic signed [DET_W-1:0]   det_lim,
  input  logic        [COEFF_W-1:0] coeff,
  output logic signed [ACC_W-1:0]   prod
);
  localparam int DW = DET_W + 1;

  logic signed [DW-1:0]    diff;
  logic signed [DW-1:0]    lim_x;
  logic signed [DW-1:0]    sel;
  logic signed [ACC_W-1:0] sel_x;
  logic signed [ACC_W-1:0] coeff_x;

  always_comb begin
    diff    = {det_cur[DET_W-1], det_cur} - {det_cal[DET_W-1], det_cal};
    lim_x   = {det_lim[DET_W-1], det_lim};
    sel     = (diff > lim_x) ? lim_x : diff;
    sel_x   = {{(ACC_W-DW){sel[DW-1]}}, sel};
    coeff_x = {{(ACC_W-COEFF_W){1'b0}}, coeff};
    prod    = sel_x * coeff_x;
  end
endmodule

// File: rtl/nfs_clamp.sv
module nfs_clamp
  import ndiv_frac_split_pkg::*;
#(
  parameter int N_W    = 8,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = 24
) (
  input  logic        [N_W-1:0]    n_eff,
  input  logic signed [ACC_W-1:0]  prod,
  input  logic        [N_W-1:0]    max_n,
  output logic        [N_W-1:0]    n_int,
  output logic        [FRAC_W-1:0] frac,
  output sat_t                     sat
);
  localparam int PAD = ACC_W - N_W - FRAC_W;

  logic signed [ACC_W-1:0] req_x;
  logic signed [ACC_W-1:0] raw;
  logic signed [ACC_W-1:0] stage1;
  logic signed [ACC_W-1:0] whole;
  logic signed [ACC_W-1:0] max_x;
  logic signed [ACC_W-1:0] fin;
  logic [ACC_W-N_W-FRAC_W-1:0] unused_hi;

  always_comb begin
    req_x  = {{PAD{1'b0}}, n_eff, {FRAC_W{1'b0}}};
    max_x  = {{(ACC_W-N_W){1'b0}}, max_n};
    raw    = req_x - prod;
    sat.lo = raw[ACC_W-1] || (raw == '0);
    stage1 = sat.lo ? (ACC_W'(1) <<< FRAC_W) : raw;
    whole  = stage1 >>> FRAC_W;
    sat.hi = whole > max_x;
    fin    = sat.hi ? {{PAD{1'b0}}, max_n, {FRAC_W{1'b0}}} : stage1;
  end

  assign n_int     = fin[FRAC_W +: N_W];
  assign frac      = fin[FRAC_W-1:0];
  assign unused_hi = fin[ACC_W-1:N_W+FRAC_W];
endmodule

// File: rtl/nfs_frac.sv
module nfs_frac #(
  parameter int FRAC_W    = 6,
  parameter int SDM_RANGE = 12,
  parameter int SDM_W     = 8
) (
  input  logic [FRAC_W-1:0] frac,
  output logic [SDM_W-1:0]  sdm
);
  localparam int SDM_FULL = SDM_RANGE + 1;
  localparam int SHIFT    = SDM_FULL - FRAC_W;
  localparam int WORD_W   = 2 * SDM_W;

  logic [WORD_W-1:0] word;
  logic [SDM_W-1:0]  unused_lo;

  always_comb begin
    word = ({{(WORD_W-FRAC_W){1'b0}}, frac} << SHIFT) - (WORD_W'(1) << SDM_RANGE);
  end

  assign sdm       = word[SDM_W +: SDM_W];
  assign unused_lo = word[SDM_W-1:0];
endmodule

// File: rtl/ndiv_frac_split.sv
module ndiv_frac_split
  import ndiv_frac_split_pkg::*;
#(
  parameter int N_W       = 8,
  parameter int DET_W     = 7,
  parameter int COEFF_W   = 7,
  parameter int FRAC_W    = 6,
  parameter int SDM_RANGE = 12,
  parameter int SDM_W     = 8,
  parameter int ACC_W     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N_W-1:0]          n_eff,
  input  logic signed [DET_W-1:0] det_cur,
  input  logic signed [DET_W-1:0] det_cal,
  input  logic signed [DET_W-1:0] det_lim,
  input  logic [COEFF_W-1:0]      coeff,
  input  logic [N_W-1:0]          max_n,
  output logic                    out_valid,
  output logic [N_W-1:0]          n_int,
  output logic [SDM_W-1:0]        sdm_din,
  output logic                    sat_lo,
  output logic                    sat_hi
);
  logic signed [ACC_W-1:0] prod;
  logic [N_W-1:0]          c_n_int;
  logic [FRAC_W-1:0]       c_frac;
  logic [SDM_W-1:0]        c_sdm;
  sat_t                    c_sat;

  logic                    d_valid;
  logic [N_W-1:0]          d_n_int;
  logic [SDM_W-1:0]        d_sdm;
  logic                    d_lo;
  logic                    d_hi;

  nfs_det_scale #(.DET_W(DET_W), .COEFF_W(COEFF_W), .ACC_W(ACC_W)) u_scale (
    .det_cur(det_cur), .det_cal(det_cal), .det_lim(det_lim),
    .coeff(coeff), .prod(prod)
  );

  nfs_clamp #(.N_W(N_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_clamp (
    .n_eff(n_eff), .prod(prod), .max_n(max_n),
    .n_int(c_n_int), .frac(c_frac), .sat(c_sat)
  );

  nfs_frac #(.FRAC_W(FRAC_W), .SDM_RANGE(SDM_RANGE), .SDM_W(SDM_W)) u_frac (
    .frac(c_frac), .sdm(c_sdm)
  );

  always_comb begin
    d_valid = in_valid;
    d_n_int = n_int;
    d_sdm   = sdm_din;
    d_lo    = sat_lo;
    d_hi    = sat_hi;
    if (in_valid) begin
      d_n_int = c_n_int;
      d_sdm   = c_sdm;
      d_lo    = c_sat.lo;
      d_hi    = c_sat.hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      n_int     <= '0;
      sdm_din   <= '0;
      sat_lo    <= 1'b0;
      sat_hi    <= 1'b0;
    end else begin
      out_valid <= d_valid;
      n_int     <= d_n_int;
      sdm_din   <= d_sdm;
      sat_lo    <= d_lo;
      sat_hi    <= d_hi;
    end
  end
endmodule

// File: rtl/ndiv_frac_split_chk.sv
module ndiv_frac_split_chk #(
  parameter int N_W       = 8,
  parameter int SDM_RANGE = 12,
  parameter int SDM_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [N_W-1:0]   max_n,
  input logic             out_valid,
  input logic [N_W-1:0]   n_int,
  input logic [SDM_W-1:0] sdm_din,
  input logic             sat_lo,
  input logic             sat_hi
);
  localparam int WW = 2 * SDM_W;
  localparam logic [WW-1:0]    HALF  = WW'(1) << SDM_RANGE;
  localparam logic [WW-1:0]    ZWORD = ~HALF + 1'b1;
  localparam logic [SDM_W-1:0] ZSDM  = ZWORD[SDM_W +: SDM_W];

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(n_int) && $stable(sdm_din) && $stable(sat_lo) && $stable(sat_hi)));

  a_r5_lo_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat_lo && !sat_hi) |-> (n_int == N_W'(1) && sdm_din == ZSDM));

  a_r6_hi_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!sat_hi || (n_int == $past(max_n) && sdm_din == ZSDM)));

  a_r8_cap: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (n_int <= $past(max_n)));
endmodule

bind ndiv_frac_split ndiv_frac_split_chk #(
  .N_W(N_W), .SDM_RANGE(SDM_RANGE), .SDM_W(SDM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .max_n(max_n),
  .out_valid(out_valid), .n_int(n_int), .sdm_din(sdm_din),
  .sat_lo(sat_lo), .sat_hi(sat_hi)
);

// File: tb/ndiv_frac_split_bench.sv
module ndiv_frac_split_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [7:0]        n_eff = '0;
  logic signed [6:0] det_cur = '0;
  logic signed [6:0] det_cal = '0;
  logic signed [6:0] det_lim = '0;
  logic [6:0]        coeff = '0;
  logic [7:0]        max_n = '0;
  logic              out_valid;
  logic [7:0]        n_int;
  logic [7:0]        sdm_din;
  logic              sat_lo;
  logic              sat_hi;

  typedef struct {
    int    n;
    int    sdm;
    bit    lo;
    bit    hi;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  int   cyc = 0;

  always #2 clk = ~clk;

  ndiv_frac_split u_ndiv_frac_split (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .n_eff(n_eff),
    .det_cur(det_cur), .det_cal(det_cal), .det_lim(det_lim), .coeff(coeff),
    .max_n(max_n), .out_valid(out_valid), .n_int(n_int), .sdm_din(sdm_din),
    .sat_lo(sat_lo), .sat_hi(sat_hi)
  );

  function automatic exp_t model(int ne, int cur, int cal, int lim, int cf, int mx, string tag);
    exp_t e;
    int d, s, r;
    d = cur - cal;
    if (d > lim) d = lim;
    s = ne * 64 - d * cf;
    e.lo = 0;
    e.hi = 0;
    if (s <= 0) begin s = 64; e.lo = 1; end
    if ((s / 64) > mx) begin s = mx * 64; e.hi = 1; end
    e.n = s / 64;
    r = (s % 64) * 128 - 4096;
    e.sdm = (r >>> 8) & 255;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(int ne, int cur, int cal, int lim, int cf, int mx, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    n_eff    = 8'(ne);
    det_cur  = 7'(cur);
    det_cal  = 7'(cal);
    det_lim  = 7'(lim);
    coeff    = 7'(cf);
    max_n    = 8'(mx);
    q.push_back(model(ne, cur, cal, lim, cf, mx, tag));
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      n_eff    = 8'($urandom_range(0, 255));
      coeff    = 7'($urandom_range(0, 127));
      max_n    = 8'($urandom_range(0, 255));
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R1: out_valid with no pending item, actual=1 expected=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (int'(n_int) != e.n || int'(sdm_din) != e.sdm || sat_lo != e.lo || sat_hi != e.hi) begin
            bad++;
            $display("FAIL %s: actual n=%0d sdm=%02h lo=%0b hi=%0b expected n=%0d sdm=%02h lo=%0b hi=%0b",
                     e.tag, n_int, sdm_din, sat_lo, sat_hi, e.n, e.sdm[7:0], e.lo, e.hi);
          end
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        total++;
        if (int'(n_int) != last.n || int'(sdm_din) != last.sdm || sat_lo != last.lo || sat_hi != last.hi) begin
          bad++;
          $display("FAIL R2: hold, actual n=%0d sdm=%02h lo=%0b hi=%0b expected n=%0d sdm=%02h lo=%0b hi=%0b",
                   n_int, sdm_din, sat_lo, sat_hi, last.n, last.sdm[7:0], last.lo, last.hi);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || n_int !== 8'h00 || sdm_din !== 8'h00 || sat_lo !== 1'b0 || sat_hi !== 1'b0) begin
      bad++;
      $display("FAIL R2: reset state, actual v=%0b n=%0d sdm=%02h lo=%0b hi=%0b expected all zero",
               out_valid, n_int, sdm_din, sat_lo, sat_hi);
    end
    rst_n = 1'b1;
    idle(2);

    // R4/R7 zero delta, fraction 0 -> F0
    drive(100, 5, 5, 63, 50, 255, "R4");
    idle(2);
    // R3 limit forces delta to 0
    drive(100, 20, 0, 0, 10, 255, "R3");
    // R3 negative delta passes the limit: n=100 f=30 -> FF
    drive(100, -10, 0, 0, 3, 255, "R3");
    // R3 positive delta under limit: n=99 f=29 -> FE
    drive(100, 5, 0, 10, 7, 255, "R3");
    idle(1);
    // R7 f=32 -> 00
    drive(10, -8, 0, 0, 4, 255, "R7");
    // R7 f=63 -> 0F
    drive(10, -9, 0, 0, 7, 255, "R7");
    idle(3);
    // R5 negative scaled divider
    drive(1, 63, 0, 63, 127, 255, "R5");
    // R5 exactly zero
    drive(1, 8, 0, 63, 8, 255, "R5");
    // R6 large overflow with extreme codes
    drive(255, -64, 63, 63, 127, 255, "R6");
    // R6 integer just above max
    drive(101, 0, 0, 0, 0, 100, "R6");
    // R6 boundary: equal to max, no flag, f=63
    drive(100, -9, 0, 0, 7, 100, "R6");
    // R6 max_n zero with underflow: both flags
    drive(0, 0, 0, 0, 0, 0, "R6");
    // R8 max_n zero with positive request
    drive(5, 0, 0, 0, 0, 0, "R8");
    idle(4);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else drive($urandom_range(0, 255), $urandom_range(0, 127) - 64,
                 $urandom_range(0, 127) - 64, $urandom_range(0, 127) - 64,
                 $urandom_range(0, 127), $urandom_range(0, 255), "R4");
    end
    idle(3);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1: pending results, actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule